// File: doc/BRIEF.md
# Three-Stage Fetch/Decode/Execute Pipeline Sequencer

This block sequences instructions through a fetch, decode and execute pipeline for a small 16-bit instruction set. It drives the instruction-memory address (the PC) and receives the addressed word in the same cycle. It keeps a valid flag for each stage and raises a retire strobe, with the PC of the retiring instruction, when an instruction completes. In steady state one instruction retires per cycle, and each instruction takes three cycles from fetch to completion.

Two instruction kinds disturb that rhythm. A load-multiple stays in execute for one cycle per register named in its mask. While it runs, the decode stage keeps holding it and the next word waits in fetch, so fetch and decode are stalled. A conditional branch tests a zero flag in execute. When the branch is taken, the two younger instructions in fetch and decode are discarded and fetch restarts at the branch target. The zero flag is written only by retiring ALU instructions.

Top module: `pipe3_seq`

## Requirements
- R1: While reset is low, `imem_addr` is 0 and `fetch_vld`, `dec_vld`, `exe_vld` and `retire` are all low.
- R2: After reset is released, `retire` is first high in the cycle that follows the third rising edge, with `retire_pc` equal to 0.
- R3: Without load-multiples or taken branches, instructions retire on consecutive cycles in ascending address order.
- R4: Encoding: bits [15:12] hold the opcode: 0 no-op, 1 ALU, 2 load-multiple, 3 branch. Any other opcode, or any word with bits [11:9] not zero, acts as a no-op. Bits [7:0] hold the ALU immediate, the register mask or the signed word offset. Bit 8 is the branch condition.
- R5: A load-multiple whose mask has N set bits occupies execute for N cycles and retires once, on its last cycle. It therefore adds N-1 cycles. An empty mask counts as one register.
- R6: While a load-multiple has execute cycles still to come, `imem_addr` stays at the load-multiple's address plus one and `dec_vld` stays high. The following instruction enters decode only during the final execute cycle.
- R7: A branch is resolved in execute. With condition bit 0 it is taken when the zero flag is 1, and with condition bit 1 it is taken when the flag is 0. The target is the branch's own address plus the sign-extended offset, wrapping modulo the address space.
- R8: A taken branch discards the two younger instructions. Neither of them retires nor writes the flag, and the next retire comes three cycles after the branch retires, which is two lost cycles.
- R9: A branch that is not taken discards nothing, and the next instruction retires in the following cycle.
- R10: `zflag` is 0 after reset. It changes only in the cycle after an ALU instruction retires, and then becomes 1 exactly when that instruction's immediate is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | PC_W | Word address of the instruction being fetched (the PC) |
| imem_rdata | input | 16 | Instruction word at `imem_addr`, valid in the same cycle |
| fetch_vld | output | 1 | Fetch stage holds a live instruction |
| dec_vld | output | 1 | Decode stage holds a live instruction |
| exe_vld | output | 1 | Execute stage holds a live instruction or load-multiple beat |
| retire | output | 1 | An instruction completes this cycle |
| retire_pc | output | PC_W | Address of the instruction signalled by `retire` |
| zflag | output | 1 | Zero flag that branches test |

## Verification
The bench runs a sweep of small programs through a cycle-counting reference interpreter and compares the retire strobe, the retire address and the flag in every cycle. Load-multiples are swept over mask sizes from empty to full. A design that miscounts the mask stretches or shortens execute by a cycle, and a design that lets the next word into decode too early shows an address that moves during the stall. Branches are swept over both conditions, both flag values and offsets of zero, one, negative and both extremes. If the design leaks a squashed ALU instruction, a stray retire appears or the flag changes, which sends a later branch the wrong way. If the design resolves a branch at the wrong stage, retires land one cycle off from the two-cycle penalty.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

    localparam int INSN_W = 16;

    localparam logic [3:0] OPC_NOP = 4'h0;
    localparam logic [3:0] OPC_ALU = 4'h1;
    localparam logic [3:0] OPC_LDM = 4'h2;
    localparam logic [3:0] OPC_BR  = 4'h3;

    typedef enum logic [1:0] {
        K_NOP = 2'd0,
        K_ALU = 2'd1,
        K_LDM = 2'd2,
        K_BR  = 2'd3
    } ikind_e;

    typedef struct packed {
        ikind_e     kind;
        logic       cond;
        logic [7:0] imm;
    } idec_t;

endpackage

// File: rtl/pipe3_idec.sv
module pipe3_idec
    import pipe3_pkg::*;
#(
    parameter int MASK_W = 8,
    parameter int CNT_W  = $clog2(MASK_W + 1)
) (
    input  logic [INSN_W-1:0] ir,
    output idec_t             dec,
    output logic [CNT_W-1:0]  beats
);

    logic [CNT_W-1:0] ones;
    logic             rsvd_ok;

    always_comb begin
        rsvd_ok = (ir[11:9] == 3'b000);
        dec.imm  = ir[7:0];
        dec.cond = ir[8];
        dec.kind = K_NOP;
        if (rsvd_ok) begin
            unique case (ir[15:12])
                OPC_ALU: dec.kind = K_ALU;
                OPC_LDM: dec.kind = K_LDM;
                OPC_BR:  dec.kind = K_BR;
                default: dec.kind = K_NOP;
            endcase
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < MASK_W; i++) begin
            ones = ones + CNT_W'(ir[i]);
        end
    end

    always_comb begin
        if (dec.kind == K_LDM && ones != '0) begin
            beats = ones;
        end else begin
            beats = CNT_W'(1);
        end
    end

    // R5: a decoded beat count is never zero and never exceeds the mask width
    always_comb begin
        a_r5_beats_range: assert (beats >= CNT_W'(1) && beats <= CNT_W'(MASK_W));
    end

endmodule

// File: rtl/pipe3_bru.sv
module pipe3_bru
    import pipe3_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic            vld,
    input  idec_t           dec,
    input  logic            flag,
    input  logic [PC_W-1:0] pc,
    output logic            taken,
    output logic [PC_W-1:0] target
);

    logic signed [PC_W-1:0] ofs;
    logic                   cond_met;

    always_comb begin
        ofs      = PC_W'($signed(dec.imm));
        target   = pc + ofs;
        cond_met = dec.cond ? ~flag : flag;
        taken    = vld && (dec.kind == K_BR) && cond_met;
    end

endmodule

// File: rtl/pipe3_seq.sv
module pipe3_seq
    import pipe3_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [INSN_W-1:0] imem_rdata,
    output logic              fetch_vld,
    output logic              dec_vld,
    output logic              exe_vld,
    output logic              retire,
    output logic [PC_W-1:0]   retire_pc,
    output logic              zflag
);

    localparam int CNT_W = $clog2(MASK_W + 1);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic             f_vld;
        logic             d_vld;
        idec_t            d_dec;
        logic [PC_W-1:0]  d_pc;
        logic [CNT_W-1:0] d_left;
        logic             x_vld;
        logic             x_last;
        idec_t            x_dec;
        logic [PC_W-1:0]  x_pc;
        logic             flag;
    } pstate_t;

    pstate_t          s_d, s_q;
    idec_t            f_dec;
    logic [CNT_W-1:0] f_beats;
    logic             br_taken;
    logic [PC_W-1:0]  br_target;
    logic             stall;
    logic             retire_w;

    pipe3_idec #(
        .MASK_W (MASK_W),
        .CNT_W  (CNT_W)
    ) u_idec (
        .ir    (imem_rdata),
        .dec   (f_dec),
        .beats (f_beats)
    );

    pipe3_bru #(
        .PC_W (PC_W)
    ) u_bru (
        .vld    (s_q.x_vld),
        .dec    (s_q.x_dec),
        .flag   (s_q.flag),
        .pc     (s_q.x_pc),
        .taken  (br_taken),
        .target (br_target)
    );

    assign retire_w = s_q.x_vld & s_q.x_last;
    assign stall    = s_q.d_vld && (s_q.d_left > CNT_W'(1)) && !br_taken;

    always_comb begin
        s_d = s_q;

        // execute stage: takes a beat from decode unless a branch squashes it
        s_d.x_vld  = s_q.d_vld & ~br_taken;
        s_d.x_last = (s_q.d_left == CNT_W'(1));
        s_d.x_dec  = s_q.d_dec;
        s_d.x_pc   = s_q.d_pc;

        // flag written by a completing ALU instruction
        if (retire_w && s_q.x_dec.kind == K_ALU) begin
            s_d.flag = (s_q.x_dec.imm == 8'h00);
        end

        // decode stage
        if (br_taken) begin
            s_d.d_vld = 1'b0;
        end else if (stall) begin
            s_d.d_left = s_q.d_left - CNT_W'(1);
        end else begin
            s_d.d_vld  = s_q.f_vld;
            s_d.d_dec  = f_dec;
            s_d.d_pc   = s_q.pc;
            s_d.d_left = f_beats;
        end

        // fetch stage
        s_d.f_vld = 1'b1;
        if (br_taken) begin
            s_d.pc = br_target;
        end else if (s_q.f_vld && !stall) begin
            s_d.pc = s_q.pc + PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign imem_addr = s_q.pc;
    assign fetch_vld = s_q.f_vld;
    assign dec_vld   = s_q.d_vld;
    assign exe_vld   = s_q.x_vld;
    assign retire    = retire_w;
    assign retire_pc = s_q.x_pc;
    assign zflag     = s_q.flag;

    // R8: after a taken branch both younger stages are empty
    a_r8_squash_empties: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (!dec_vld && !exe_vld));

    // R7: fetch restarts at the branch target
    a_r7_restart_target: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (imem_addr == $past(br_target)));

    // R6: a pending load-multiple beat freezes fetch and keeps decode occupied
    a_r6_hold_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (imem_addr == $past(imem_addr) && dec_vld));

    // R5: a non-final load-multiple beat is always followed by another beat
    a_r5_beats_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_vld && !s_q.x_last) |=> (exe_vld && !retire_w ? 1'b1 : exe_vld));

    // R10: flag holds unless an ALU instruction retired
    a_r10_flag_only_alu: assert property (@(posedge clk) disable iff (!rst_n)
        !(retire_w && s_q.x_dec.kind == K_ALU) |=> $stable(zflag));

    // R8: a taken branch is itself the retiring instruction
    a_r8_branch_retires: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> retire_w);

endmodule

// File: tb/pipe3_seq_tb_top.sv
module pipe3_seq_tb_top;

    localparam int PC_W = 8;
    localparam int NC   = 96;
    localparam int WD_LIMIT = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   imem_addr;
    logic [15:0]       imem_rdata;
    logic              fetch_vld, dec_vld, exe_vld, retire, zflag;
    logic [PC_W-1:0]   retire_pc;

    logic [15:0]       mem [256];

    always #10 clk = ~clk;

    assign imem_rdata = mem[imem_addr];

    pipe3_seq #(.PC_W(PC_W), .MASK_W(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .fetch_vld  (fetch_vld),
        .dec_vld    (dec_vld),
        .exe_vld    (exe_vld),
        .retire     (retire),
        .retire_pc  (retire_pc),
        .zflag      (zflag)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int wd_cnt = 0;

    logic       exp_ret  [NC];
    logic [7:0] exp_rpc  [NC];
    logic       exp_achk [NC];
    logic [7:0] exp_addr [NC];
    logic       exp_flg  [NC];
    int         flg_ev   [NC];

    function automatic logic [15:0] e_nop();
        return 16'h0000;
    endfunction
    function automatic logic [15:0] e_alu(input logic [7:0] imm);
        return {4'h1, 4'h0, imm};
    endfunction
    function automatic logic [15:0] e_ldm(input logic [7:0] mask);
        return {4'h2, 4'h0, mask};
    endfunction
    function automatic logic [15:0] e_br(input logic cond, input logic [7:0] off);
        return {4'h3, 3'b000, cond, off};
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = e_nop();
    endtask

    // Reference interpreter: cycle c = c-th rising edge after reset release
    task automatic build_expect();
        logic [7:0] pc;
        logic       flag;
        logic [15:0] ins;
        int t, n, r;
        logic tk;
        for (int c = 0; c < NC; c++) begin
            exp_ret[c] = 1'b0; exp_rpc[c] = '0; exp_achk[c] = 1'b0;
            exp_addr[c] = '0; flg_ev[c] = -1;
        end
        pc = 8'd0; flag = 1'b0; t = 3;
        while (t < NC) begin
            ins = mem[pc];
            if (ins[11:9] != 3'b000) ins = 16'h0000;
            case (ins[15:12])
                4'h2: begin
                    n = $countones(ins[7:0]);
                    if (n == 0) n = 1;
                    for (int c = t; c < t + n - 1; c++)
                        if (c < NC) begin exp_achk[c] = 1'b1; exp_addr[c] = pc + 8'd1; end
                    r = t + n - 1;
                    if (r < NC) begin exp_ret[r] = 1'b1; exp_rpc[r] = pc; end
                    t = r + 1; pc = pc + 8'd1;
                end
                4'h3: begin
                    exp_ret[t] = 1'b1; exp_rpc[t] = pc;
                    tk = ins[8] ? ~flag : flag;
                    if (tk) begin pc = pc + ins[7:0]; t = t + 3; end
                    else begin pc = pc + 8'd1; t = t + 1; end
                end
                4'h1: begin
                    exp_ret[t] = 1'b1; exp_rpc[t] = pc;
                    flag = (ins[7:0] == 8'h00);
                    if (t + 1 < NC) flg_ev[t+1] = int'(flag);
                    pc = pc + 8'd1; t = t + 1;
                end
                default: begin
                    exp_ret[t] = 1'b1; exp_rpc[t] = pc;
                    pc = pc + 8'd1; t = t + 1;
                end
            endcase
        end
        flag = 1'b0;
        for (int c = 0; c < NC; c++) begin
            if (flg_ev[c] >= 0) flag = flg_ev[c][0];
            exp_flg[c] = flag;
        end
    endtask

    task automatic run_prog(input string tag);
        build_expect();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(imem_addr == '0, "R1", "imem_addr in reset", int'(imem_addr), 0);
        chk(!fetch_vld && !dec_vld && !exe_vld, "R1", "stage valids in reset",
            int'({fetch_vld, dec_vld, exe_vld}), 0);
        chk(!retire, "R1", "retire in reset", int'(retire), 0);
        rst_n = 1'b1;
        for (int c = 1; c < NC; c++) begin
            @(posedge clk);
            @(negedge clk);
            chk(retire == exp_ret[c], tag, $sformatf("retire at cycle %0d", c),
                int'(retire), int'(exp_ret[c]));
            if (exp_ret[c] && retire)
                chk(retire_pc == exp_rpc[c], tag, $sformatf("retire_pc at cycle %0d", c),
                    int'(retire_pc), int'(exp_rpc[c]));
            if (exp_achk[c]) begin
                chk(imem_addr == exp_addr[c], "R6", $sformatf("held imem_addr at cycle %0d", c),
                    int'(imem_addr), int'(exp_addr[c]));
                chk(dec_vld, "R6", $sformatf("dec_vld during beats at cycle %0d", c),
                    int'(dec_vld), 1);
            end
            chk(zflag == exp_flg[c], "R10", $sformatf("zflag at cycle %0d", c),
                int'(zflag), int'(exp_flg[c]));
        end
    endtask

    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt >= WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<%0d", wd_cnt, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R2 R3 R4: straight-line code, reserved-bit and unknown opcodes act as no-ops
        clear_mem();
        mem[0] = e_alu(8'd5);
        mem[1] = e_nop();
        mem[2] = e_alu(8'd0);
        mem[3] = 16'h7012;
        mem[4] = 16'h1200;
        mem[5] = 16'h3E01;
        mem[6] = e_alu(8'd9);
        run_prog("R2 R3 R4");

        // R5 R6: load-multiple swept over mask populations 0..8
        for (int k = 0; k <= 8; k++) begin
            clear_mem();
            mem[0] = e_alu(8'd0);
            mem[1] = e_ldm(8'((16'd1 << k) - 16'd1));
            mem[2] = e_alu(8'd1);
            mem[3] = e_ldm(8'hA5);
            mem[4] = e_ldm(8'h80);
            run_prog("R5 R6");
        end

        // R7 R8 R9: both conditions against both flag values; squashed ALUs would flip flag
        for (int fv = 0; fv < 2; fv++) begin
            for (int cd = 0; cd < 2; cd++) begin
                clear_mem();
                mem[0] = e_alu(fv != 0 ? 8'd0 : 8'd3);
                mem[1] = e_br(cd[0], 8'd4);
                mem[2] = e_alu(fv != 0 ? 8'd3 : 8'd0);
                mem[3] = e_alu(fv != 0 ? 8'd7 : 8'd0);
                mem[5] = e_br(cd[0], 8'hFB);
                mem[6] = e_alu(8'd0);
                run_prog("R7 R8 R9");
            end
        end

        // R7 R8: offset sweep including zero, one and the extremes
        begin
            logic [7:0] offs [6];
            offs[0] = 8'hFD; offs[1] = 8'h00; offs[2] = 8'h01;
            offs[3] = 8'h02; offs[4] = 8'h7F; offs[5] = 8'h80;
            for (int j = 0; j < 6; j++) begin
                clear_mem();
                mem[0] = e_alu(8'd0);
                mem[3] = e_br(1'b0, offs[j]);
                mem[4] = e_alu(8'd2);
                mem[8'd3 + 8'h7F] = e_alu(8'd1);
                run_prog("R7 R8");
            end
        end

        // R5 R8 R9: load-multiple next to branches, squashed load-multiple
        clear_mem();
        mem[0] = e_ldm(8'hFF);
        mem[1] = e_alu(8'd0);
        mem[2] = e_br(1'b0, 8'd6);
        mem[3] = e_ldm(8'h03);
        mem[8] = e_ldm(8'h0F);
        mem[9] = e_br(1'b1, 8'hF7);
        mem[10] = e_alu(8'd4);
        mem[11] = e_br(1'b1, 8'hF5);
        run_prog("R5 R8 R9");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule